// File: doc/BRIEF.md
# DRAM ECC Error Capture Registers

This block sits beside a memory controller's ECC checker. It records correctable and uncorrectable error events, plus three housekeeping events from elsewhere in the controller (refresh timeout, lock error on a non-DRAM target, thermal trip), in a small register file that software polls or is interrupted into. For the first error logged it keeps the cache-line pointer, the channel, address bit 32, the ECC syndrome and the requester code.

Capture follows a severity rule. An uncorrectable error replaces the details of a correctable error that is already logged. A correctable error never replaces anything that is already logged. Software clears the status by writing ones. Three command registers hold per-event enables. They pick one signalling path, and a report output on that path rises while an enabled status bit is set.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads zero and all three report outputs are low.
- R2: A `ceIn` pulse sets status bit 0, `ueIn` sets bit 1, `refreshToIn` sets bit 8, `lockErrIn` sets bit 9 and `thermalIn` sets bit 11. All other status bits read zero.
- R3: Writing a 1 to a status bit clears it and writing a 0 leaves it alone. A byte lane takes part only when its byte enable is set: `regBe[0]` covers bits 7:0 and `regBe[1]` covers bits 15:8.
- R4: If an event and a clear of its status bit fall in the same cycle, the bit stays set. The clear also frees the log, so that event's details are captured.
- R5: The pointer reads as {address bits 31:7, six zero bits, channel}. Its bits 15:0 are at offset 1 and bits 31:16 at offset 2. The extension register at offset 3 holds address bit 32 in bit 0 and zeros elsewhere.
- R6: A correctable error arriving while the log is empty captures the pointer, extension bit, syndrome (offset 4) and destination code (offset 5).
- R7: An uncorrectable error arriving while only a correctable error is logged overwrites all captured details, and both status bits 1:0 read set.
- R8: A correctable error arriving while any error is logged, or an uncorrectable error arriving while one is already logged, leaves every captured detail unchanged.
- R9: A correctable and an uncorrectable error in the same cycle on an empty log capture one set of details and set both status bits.
- R10: The command register at offset 6 keeps only bits 0, 1, 8, 9 and 11. The registers at offsets 7 and 8 keep only bits 1:0. Writes to offsets 0 to 5 never load data; offset 0 only clears.
- R11: The selected path's report output is high exactly when the status and that path's enables share a set bit.
- R12: The selected path is offset 6 if it has any enable set, otherwise offset 7 if it has any enable set, otherwise offset 8. Unselected outputs stay low.
- R13: A read request presents the addressed register on `regRdata` one clock later, and that value holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceIn | input | 1 | Correctable-error pulse |
| ueIn | input | 1 | Uncorrectable-error pulse |
| refreshToIn | input | 1 | Refresh timeout pulse |
| lockErrIn | input | 1 | Non-DRAM lock error pulse |
| thermalIn | input | 1 | Thermal sensor event pulse |
| errAddr | input | 33 | Byte address of the failing access |
| errChan | input | 1 | Channel of the failing access |
| errSyn | input | 8 | ECC syndrome |
| errDest | input | 8 | Requester code (0 = processor read) |
| regAddr | input | 4 | Register offset |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regBe | input | 2 | Byte enables |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, one cycle after `regRd` |
| reportSerr | output | 1 | Report on the system-error path |
| reportSmi | output | 1 | Report on the management-interrupt path |
| reportSci | output | 1 | Report on the control-interrupt path |

## Verification
Two things can land in the same clock edge: a software clear of the status and a fresh error from the checker. The bench drives a one-ones write to status together with a new correctable pulse on one negative edge. It then reads back that the status bit is still set and that the syndrome is the new error's, not the old one's. Simultaneous correctable and uncorrectable pulses are also driven together, and the bench checks that both status bits end up set.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W    = 16;
  localparam int LANES    = REG_W / 8;
  localparam int PTR_W    = 2 * REG_W;
  localparam int ADDR_W   = PTR_W + 1;
  localparam int LINE_LSB = 7;
  localparam int SYN_W    = 8;
  localparam int DEST_W   = 8;
  localparam int MAP_W    = 4;

  localparam logic [REG_W-1:0] STAT_MASK  = 16'h0B03;
  localparam logic [REG_W-1:0] SERR_MASK  = 16'h0B03;
  localparam logic [REG_W-1:0] LOCAL_MASK = 16'h0003;

  localparam logic [MAP_W-1:0] OFS_STAT   = 4'd0;
  localparam logic [MAP_W-1:0] OFS_PTR_LO = 4'd1;
  localparam logic [MAP_W-1:0] OFS_PTR_HI = 4'd2;
  localparam logic [MAP_W-1:0] OFS_EXT    = 4'd3;
  localparam logic [MAP_W-1:0] OFS_SYN    = 4'd4;
  localparam logic [MAP_W-1:0] OFS_DEST   = 4'd5;
  localparam logic [MAP_W-1:0] OFS_SERR   = 4'd6;
  localparam logic [MAP_W-1:0] OFS_SMI    = 4'd7;
  localparam logic [MAP_W-1:0] OFS_SCI    = 4'd8;

  typedef struct packed {
    logic capture;
    logic wrSerr;
    logic wrSmi;
    logic wrSci;
  } capStrobe_t;
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceIn,
  input  logic             ueIn,
  input  logic             refreshToIn,
  input  logic             lockErrIn,
  input  logic             thermalIn,
  input  logic [MAP_W-1:0] regAddr,
  input  logic             regWr,
  input  logic [LANES-1:0] regBe,
  input  logic [REG_W-1:0] regWdata,
  input  logic [REG_W-1:0] serrEn,
  input  logic [REG_W-1:0] smiEn,
  input  logic [REG_W-1:0] sciEn,
  output logic [REG_W-1:0] statusOut,
  output capStrobe_t       strobe,
  output logic             reportSerr,
  output logic             reportSmi,
  output logic             reportSci
);
  logic [REG_W-1:0] statusReg;
  logic [REG_W-1:0] laneMask;
  logic [REG_W-1:0] clrBits;
  logic [REG_W-1:0] setBits;
  logic [REG_W-1:0] held;
  logic             statWr;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign laneMask[gl*8 +: 8] = {8{regBe[gl]}};
  end

  assign statWr  = regWr && (regAddr == OFS_STAT);
  assign clrBits = statWr ? (regWdata & laneMask & STAT_MASK) : '0;

  always_comb begin
    setBits     = '0;
    setBits[0]  = ceIn;
    setBits[1]  = ueIn;
    setBits[8]  = refreshToIn;
    setBits[9]  = lockErrIn;
    setBits[11] = thermalIn;
  end

  // A clear in this cycle frees the log before the incoming event is judged.
  assign held = statusReg & ~clrBits;

  always_comb begin
    strobe.capture = (ueIn && !held[1]) || (ceIn && !ueIn && !held[1] && !held[0]);
    strobe.wrSerr  = regWr && (regAddr == OFS_SERR);
    strobe.wrSmi   = regWr && (regAddr == OFS_SMI);
    strobe.wrSci   = regWr && (regAddr == OFS_SCI);
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= held | setBits;
  end

  assign statusOut = statusReg;

  always_comb begin
    reportSerr = 1'b0;
    reportSmi  = 1'b0;
    reportSci  = 1'b0;
    if (|serrEn)     reportSerr = |(statusReg & serrEn);
    else if (|smiEn) reportSmi  = |(statusReg & smiEn);
    else             reportSci  = |(statusReg & sciEn);
  end

  a_r2_ce_sets: assert property (@(posedge clk) disable iff (!rstN)
    ceIn |=> statusOut[0]);
  a_r7_ue_sets: assert property (@(posedge clk) disable iff (!rstN)
    ueIn |=> statusOut[1]);
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && regBe[0] && regWdata[0] && !ceIn) |=> !statusOut[0]);
  a_r12_single_path: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reportSerr, reportSmi, reportSci}));
endmodule

// File: rtl/ecc_cap_dp.sv
module ecc_cap_dp
  import ecc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              errChan,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic [DEST_W-1:0] errDest,
  input  logic [MAP_W-1:0]  regAddr,
  input  logic              regRd,
  input  logic [LANES-1:0]  regBe,
  input  logic [REG_W-1:0]  regWdata,
  input  logic [REG_W-1:0]  statusIn,
  output logic [REG_W-1:0]  serrEn,
  output logic [REG_W-1:0]  smiEn,
  output logic [REG_W-1:0]  sciEn,
  output logic [REG_W-1:0]  regRdata
);
  logic [PTR_W-1:0]  ptrReg;
  logic              extReg;
  logic [SYN_W-1:0]  synReg;
  logic [DEST_W-1:0] destReg;
  logic [REG_W-1:0]  rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg  <= '0;
      extReg  <= 1'b0;
      synReg  <= '0;
      destReg <= '0;
    end else if (strobe.capture) begin
      ptrReg  <= {errAddr[PTR_W-1:LINE_LSB], {(LINE_LSB-1){1'b0}}, errChan};
      extReg  <= errAddr[ADDR_W-1];
      synReg  <= errSyn;
      destReg <= errDest;
    end
  end

  for (genvar gl = 0; gl < LANES; gl++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (!rstN) begin
        serrEn[gl*8 +: 8] <= '0;
        smiEn[gl*8 +: 8]  <= '0;
        sciEn[gl*8 +: 8]  <= '0;
      end else begin
        if (strobe.wrSerr && regBe[gl])
          serrEn[gl*8 +: 8] <= regWdata[gl*8 +: 8] & SERR_MASK[gl*8 +: 8];
        if (strobe.wrSmi && regBe[gl])
          smiEn[gl*8 +: 8] <= regWdata[gl*8 +: 8] & LOCAL_MASK[gl*8 +: 8];
        if (strobe.wrSci && regBe[gl])
          sciEn[gl*8 +: 8] <= regWdata[gl*8 +: 8] & LOCAL_MASK[gl*8 +: 8];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    case (regAddr)
      OFS_STAT:   rdNext = statusIn;
      OFS_PTR_LO: rdNext = ptrReg[REG_W-1:0];
      OFS_PTR_HI: rdNext = ptrReg[PTR_W-1:REG_W];
      OFS_EXT:    rdNext = {{(REG_W-1){1'b0}}, extReg};
      OFS_SYN:    rdNext = {{(REG_W-SYN_W){1'b0}}, synReg};
      OFS_DEST:   rdNext = {{(REG_W-DEST_W){1'b0}}, destReg};
      OFS_SERR:   rdNext = serrEn;
      OFS_SMI:    rdNext = smiEn;
      OFS_SCI:    rdNext = sciEn;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      regRdata <= '0;
    else if (regRd) regRdata <= rdNext;
  end

  a_r8_details_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(ptrReg) && $stable(synReg) && $stable(destReg) && $stable(extReg)));
  a_r6_syn_loads: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (synReg == $past(errSyn)));
  a_r13_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> $stable(regRdata));
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceIn,
  input  logic              ueIn,
  input  logic              refreshToIn,
  input  logic              lockErrIn,
  input  logic              thermalIn,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              errChan,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic [DEST_W-1:0] errDest,
  input  logic [MAP_W-1:0]  regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [LANES-1:0]  regBe,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              reportSerr,
  output logic              reportSmi,
  output logic              reportSci
);
  capStrobe_t       strobe;
  logic [REG_W-1:0] statusVal;
  logic [REG_W-1:0] serrEn;
  logic [REG_W-1:0] smiEn;
  logic [REG_W-1:0] sciEn;

  ecc_cap_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .ceIn(ceIn), .ueIn(ueIn), .refreshToIn(refreshToIn),
    .lockErrIn(lockErrIn), .thermalIn(thermalIn),
    .regAddr(regAddr), .regWr(regWr), .regBe(regBe), .regWdata(regWdata),
    .serrEn(serrEn), .smiEn(smiEn), .sciEn(sciEn),
    .statusOut(statusVal), .strobe(strobe),
    .reportSerr(reportSerr), .reportSmi(reportSmi), .reportSci(reportSci)
  );

  ecc_cap_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .errAddr(errAddr), .errChan(errChan), .errSyn(errSyn), .errDest(errDest),
    .regAddr(regAddr), .regRd(regRd), .regBe(regBe), .regWdata(regWdata),
    .statusIn(statusVal),
    .serrEn(serrEn), .smiEn(smiEn), .sciEn(sciEn),
    .regRdata(regRdata)
  );
endmodule

// File: tb/test_ecc_err_capture.sv
module test_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceIn = 0, ueIn = 0, refreshToIn = 0, lockErrIn = 0, thermalIn = 0;
  logic [32:0] errAddr = '0;
  logic        errChan = 0;
  logic [7:0]  errSyn = '0, errDest = '0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 0, regRd = 0;
  logic [1:0]  regBe = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        reportSerr, reportSmi, reportSci;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  ecc_err_capture i_ecc_err_capture (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .ueIn(ueIn), .refreshToIn(refreshToIn),
    .lockErrIn(lockErrIn), .thermalIn(thermalIn), .errAddr(errAddr), .errChan(errChan),
    .errSyn(errSyn), .errDest(errDest), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regBe(regBe), .regWdata(regWdata), .regRdata(regRdata),
    .reportSerr(reportSerr), .reportSmi(reportSmi), .reportSci(reportSci)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; regRd = 1;
    @(negedge clk); regRd = 0; d = regRdata;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); regAddr = a; regBe = be; regWdata = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  // kinds = {thermal, lock, refresh, ue, ce}
  task automatic setEvt(input logic [4:0] kinds, input logic [32:0] a, input logic ch,
                        input logic [7:0] s, input logic [7:0] d);
    {thermalIn, lockErrIn, refreshToIn, ueIn, ceIn} = kinds;
    errAddr = a; errChan = ch; errSyn = s; errDest = d;
  endtask

  task automatic fire(input logic [4:0] kinds, input logic [32:0] a, input logic ch,
                      input logic [7:0] s, input logic [7:0] d);
    @(negedge clk); setEvt(kinds, a, ch, s, d);
    @(negedge clk); setEvt(5'b0, '0, 0, '0, '0);
  endtask

  task automatic clearAll();
    writeReg(4'd0, 2'b11, 16'hFFFF);
  endtask

  task automatic tReset();
    readReg(4'd0, rv); check("R1 status", rv, 16'h0000);
    readReg(4'd4, rv); check("R1 syndrome", rv, 16'h0000);
    readReg(4'd1, rv); check("R1 pointer", rv, 16'h0000);
    check("R1 reports", {13'b0, reportSerr, reportSmi, reportSci}, 16'h0000);
  endtask

  task automatic tCeCapture();
    fire(5'b00001, 33'h1_2345_67FF, 1'b1, 8'h5A, 8'h00);
    readReg(4'd0, rv); check("R2 ce bit", rv, 16'h0001);
    readReg(4'd1, rv); check("R5 ptr low", rv, 16'h6781);
    readReg(4'd2, rv); check("R5 ptr high", rv, 16'h2345);
    readReg(4'd3, rv); check("R5 ext bit", rv, 16'h0001);
    readReg(4'd4, rv); check("R6 syndrome", rv, 16'h005A);
    readReg(4'd5, rv); check("R6 dest", rv, 16'h0000);
  endtask

  task automatic tCeNoOverwrite();
    fire(5'b00001, 33'h0_1111_2200, 1'b0, 8'h11, 8'h03);
    readReg(4'd4, rv); check("R8 ce keeps syn", rv, 16'h005A);
    readReg(4'd1, rv); check("R8 ce keeps ptr", rv, 16'h6781);
  endtask

  task automatic tUeOverwrite();
    fire(5'b00010, 33'h0_89AB_CD00, 1'b0, 8'hC3, 8'h02);
    readReg(4'd0, rv); check("R7 both bits", rv, 16'h0003);
    readReg(4'd4, rv); check("R7 syndrome", rv, 16'h00C3);
    readReg(4'd2, rv); check("R7 ptr high", rv, 16'h89AB);
    readReg(4'd3, rv); check("R7 ext bit", rv, 16'h0000);
    readReg(4'd5, rv); check("R7 dest", rv, 16'h0002);
  endtask

  task automatic tNoOverwriteUe();
    fire(5'b00001, 33'h0_1111_2200, 1'b0, 8'h11, 8'h03);
    readReg(4'd4, rv); check("R8 ce under ue", rv, 16'h00C3);
    fire(5'b00010, 33'h1_0000_0080, 1'b1, 8'h77, 8'h01);
    readReg(4'd4, rv); check("R8 ue under ue syn", rv, 16'h00C3);
    readReg(4'd1, rv); check("R8 ue under ue ptr", rv, 16'hCD00);
  endtask

  task automatic tW1c();
    writeReg(4'd0, 2'b01, 16'h0001);
    readReg(4'd0, rv); check("R3 clear bit0", rv, 16'h0002);
    writeReg(4'd0, 2'b10, 16'h0002);
    readReg(4'd0, rv); check("R3 lane off", rv, 16'h0002);
    writeReg(4'd0, 2'b11, 16'h0000);
    readReg(4'd0, rv); check("R3 zero write", rv, 16'h0002);
    writeReg(4'd0, 2'b01, 16'h0002);
    readReg(4'd0, rv); check("R3 clear bit1", rv, 16'h0000);
  endtask

  task automatic tSimul();
    fire(5'b00011, 33'h1_FFFF_FF80, 1'b1, 8'hEE, 8'h05);
    readReg(4'd0, rv); check("R9 both bits", rv, 16'h0003);
    readReg(4'd4, rv); check("R9 syndrome", rv, 16'h00EE);
    readReg(4'd1, rv); check("R9 ptr low", rv, 16'hFF81);
  endtask

  task automatic tClearRace();
    clearAll();
    fire(5'b00001, 33'h1_2345_67FF, 1'b1, 8'h5A, 8'h00);
    @(negedge clk);
    regAddr = 4'd0; regBe = 2'b01; regWdata = 16'h0001; regWr = 1;
    setEvt(5'b00001, 33'h0_1111_2200, 1'b0, 8'h11, 8'h03);
    @(negedge clk);
    regWr = 0; setEvt(5'b0, '0, 0, '0, '0);
    readReg(4'd0, rv); check("R4 bit survives clear", rv, 16'h0001);
    readReg(4'd4, rv); check("R4 new details", rv, 16'h0011);
  endtask

  task automatic tOtherEvents();
    clearAll();
    fire(5'b00100, '0, 0, '0, '0);
    readReg(4'd0, rv); check("R2 refresh bit", rv, 16'h0100);
    fire(5'b01000, '0, 0, '0, '0);
    readReg(4'd0, rv); check("R2 lock bit", rv, 16'h0300);
    fire(5'b10000, '0, 0, '0, '0);
    readReg(4'd0, rv); check("R2 thermal bit", rv, 16'h0B00);
    writeReg(4'd0, 2'b10, 16'h0800);
    readReg(4'd0, rv); check("R3 upper lane clear", rv, 16'h0300);
  endtask

  task automatic tCmdMask();
    writeReg(4'd6, 2'b11, 16'hFFFF);
    readReg(4'd6, rv); check("R10 serr mask", rv, 16'h0B03);
    writeReg(4'd7, 2'b11, 16'hFFFF);
    readReg(4'd7, rv); check("R10 smi mask", rv, 16'h0003);
    writeReg(4'd8, 2'b10, 16'hFFFF);
    readReg(4'd8, rv); check("R10 sci lane off", rv, 16'h0000);
    writeReg(4'd8, 2'b01, 16'hFFFF);
    readReg(4'd8, rv); check("R10 sci mask", rv, 16'h0003);
    writeReg(4'd4, 2'b11, 16'hFFFF);
    readReg(4'd4, rv); check("R10 syndrome read-only", rv, 16'h0011);
  endtask

  task automatic tReport();
    // status is 0x0300 here
    @(negedge clk);
    check("R11 serr on", {13'b0, reportSerr, reportSmi, reportSci}, 16'h0004);
    writeReg(4'd6, 2'b11, 16'h0000);
    @(negedge clk);
    check("R11 smi idle", {13'b0, reportSerr, reportSmi, reportSci}, 16'h0000);
    fire(5'b00001, 33'h0_0000_0100, 1'b0, 8'h22, 8'h00);
    check("R12 smi chosen", {13'b0, reportSerr, reportSmi, reportSci}, 16'h0002);
    writeReg(4'd7, 2'b11, 16'h0000);
    @(negedge clk);
    check("R12 sci chosen", {13'b0, reportSerr, reportSmi, reportSci}, 16'h0001);
    writeReg(4'd6, 2'b10, 16'h0800);
    @(negedge clk);
    check("R12 serr masks sci", {13'b0, reportSerr, reportSmi, reportSci}, 16'h0000);
  endtask

  task automatic tLatency();
    @(negedge clk); regAddr = 4'd0; regRd = 1;
    @(negedge clk); regRd = 0; regAddr = 4'd6;
    check("R13 one-cycle read", regRdata, 16'h0301);
    @(negedge clk);
    check("R13 data holds", regRdata, 16'h0301);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tCeCapture();
    tCeNoOverwrite();
    tUeOverwrite();
    tNoOverwriteUe();
    tW1c();
    tSimul();
    tClearRace();
    tOtherEvents();
    tCmdMask();
    tReport();
    tLatency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule